// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block sits between DMA-capable devices and memory. It turns a device's IO address into a real memory address by walking a two-level structure: a segment table, and then a page table. Both tables live in memory. The IO space is cut into 256 MB segments. Each segment entry names its own page table, the length of that table, and the page size of the segment, which may be 4 KB or 64 KB. The final page entry grants read and/or write permission.

A requester presents one request at a time. Each request carries an IO address, a read/write direction and an 11-bit device ID. The block answers with a single-cycle response that holds either the real address or a fault flag. Table entries are fetched through a simple memory read port that has at most one read in flight.

Four registers sit behind a small write/readback port:
- a table origin register;
- a configuration register holding the translation enable;
- an exception status register;
- an exception mask register.

The first fault is recorded in the status register. An interrupt is raised while that record is valid and its fault type is enabled in the mask.

Top module: `ioxl_top`

## Requirements
- R1: When configuration bit 47 or origin bit 63 is clear, a request is answered with `rsp_addr` equal to `req_addr` (zero-extended), `rsp_fault` low, and no memory read.
- R2: The segment entry is read from (origin bits 41:12 × 4096) + 8 × IO address bits 34:28. A segment index greater than origin bits 7:0 gives a segment fault without any memory read.
- R3: A segment entry whose bit 63 is clear, or whose page-size code (bits 2:0) is neither 1 (4 KB) nor 3 (64 KB), gives a segment fault.
- R4: The page entry is read from (segment bits 41:12 × 4096) + 8 × index. The index is IO address bits 27:12 for 4 KB pages and bits 27:16 for 64 KB pages. An index at or above (segment bits 11:5 + 1) × 512 gives a page fault without a page read.
- R5: On success, `rsp_addr` is page-entry bits 41:12 followed by 12 zero bits, with the low 12 bits (4 KB) or low 16 bits (64 KB) replaced by the IO address offset.
- R6: A read needs page-entry bit 62 and a write needs page-entry bit 63. If the needed bit is missing, the result is a page fault.
- R7: A fault recorded while status is not valid sets the status word as follows: bit 63 = 1; bits 62:61 = 11 for a segment fault or 10 for a page fault; bits 34:12 = the IO address bits 34:12; bit 11 = 1 for a read; bits 10:0 = device ID.
- R8: While status bit 63 is set, later faults still return `rsp_fault` but leave the status word unchanged.
- R9: `irq` is high exactly while status is valid and either the type is 11 with mask bit 62 set, or the type is 10 with mask bit 61 set.
- R10: Writing the status register with bit 63 clear clears the valid flag, and `irq` drops.
- R11: `req_ready` is low from acceptance until after the single-cycle `rsp_valid` pulse.
- R12: `reg_sel` codes 0 = origin, 1 = configuration, 2 = status, 3 = mask. `reg_rdata` returns the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 35 | IO address |
| req_is_read | input | 1 | 1 = read access, 0 = write |
| req_id | input | 11 | Device ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | RA_W | Real address |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | Entry read request, held until data |
| mem_addr | output | RA_W | Entry byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Selected register value |
| irq | output | 1 | Fault interrupt |

## Verification
Requests are tried in several forms:
- with translation off;
- through a 4 KB segment and through a 64 KB segment, so the two index and offset splits are told apart;
- with read-only and write-only page entries in both directions, so each permission bit is tested on its own;
- against an invalid segment entry, an unsupported page size, an out-of-range segment index and an out-of-range page index.

The memory-read count separates faults found before a fetch from faults found after one. Interleaving fault capture with mask writes and acknowledgement shows which fault type drives the interrupt, and that a held record is not overwritten.

// File: rtl/ioxl_pkg.sv
package ioxl_pkg;
    localparam int IOA_W    = 35;
    localparam int ID_W     = 11;
    localparam int DW       = 64;
    localparam int SEG_IDX_W = IOA_W - 28;
    localparam int PG_IDX_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PG   = 2'd2,
        ST_RESP = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        SEL_ORIGIN = 2'd0,
        SEL_CONFIG = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_MASK   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] KIND_SEG  = 2'b11;
    localparam logic [1:0] KIND_PAGE = 2'b10;

    typedef struct packed {
        logic             valid;
        logic [1:0]       kind;
        logic [22:0]      page;
        logic             is_read;
        logic [ID_W-1:0]  id;
    } exc_t;
endpackage

// File: rtl/ioxl_regs.sv
module ioxl_regs
    import ioxl_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              cap_en,
    input  exc_t              cap_val,
    output logic              walk_en,
    output logic [RA_W-13:0]  tbl_rpn,
    output logic [7:0]        seg_limit,
    output exc_t              exc,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    localparam logic [DW-1:0] ORG_KEEP =
        (64'h1 << 63) | (((64'h1 << RA_W) - 1) & ~64'hFFF) | 64'hFF;

    typedef struct packed {
        logic [DW-1:0] origin;
        logic          te;
        exc_t          exc;
        logic          seg_ie;
        logic          pg_ie;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_ORIGIN: r_d.origin = reg_wdata & ORG_KEEP;
                SEL_CONFIG: r_d.te     = reg_wdata[47];
                SEL_STATUS: begin
                    r_d.exc.valid   = reg_wdata[63];
                    r_d.exc.kind    = reg_wdata[62:61];
                    r_d.exc.page    = reg_wdata[34:12];
                    r_d.exc.is_read = reg_wdata[11];
                    r_d.exc.id      = reg_wdata[10:0];
                end
                default: begin
                    r_d.seg_ie = reg_wdata[62];
                    r_d.pg_ie  = reg_wdata[61];
                end
            endcase
        end
        if (cap_en && !r_q.exc.valid)
            r_d.exc = cap_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign walk_en   = r_q.te && r_q.origin[63];
    assign tbl_rpn   = r_q.origin[RA_W-1:12];
    assign seg_limit = r_q.origin[7:0];
    assign exc       = r_q.exc;
    assign irq       = r_q.exc.valid &&
                       ((r_q.exc.kind == KIND_SEG  && r_q.seg_ie) ||
                        (r_q.exc.kind == KIND_PAGE && r_q.pg_ie));

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_ORIGIN: reg_rdata = r_q.origin;
            SEL_CONFIG: reg_rdata = {16'b0, r_q.te, 47'b0};
            SEL_STATUS: reg_rdata = {r_q.exc.valid, r_q.exc.kind, 26'b0,
                                     r_q.exc.page, r_q.exc.is_read, r_q.exc.id};
            default:    reg_rdata = {1'b0, r_q.seg_ie, r_q.pg_ie, 61'b0};
        endcase
    end
endmodule

// File: rtl/ioxl_pgcalc.sv
module ioxl_pgcalc
    import ioxl_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic [IOA_W-1:0] io_addr,
    input  logic [RA_W-13:0] pt_rpn,
    input  logic [6:0]       pt_pages_m1,
    input  logic             is64k,
    output logic             idx_ok,
    output logic [RA_W-1:0]  pte_addr
);
    localparam int ENT_PER_PG_SH = 9;
    logic [PG_IDX_W-1:0] idx;

    always_comb begin
        if (is64k) idx = {4'b0, io_addr[27:16]};
        else       idx = io_addr[27:12];
        idx_ok   = idx[PG_IDX_W-1:ENT_PER_PG_SH] <= pt_pages_m1;
        pte_addr = {pt_rpn, 12'b0} + RA_W'({idx, 3'b000});
    end
endmodule

// File: rtl/ioxl_walk.sv
module ioxl_walk
    import ioxl_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IOA_W-1:0]  req_addr,
    input  logic              req_is_read,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [RA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    input  logic              walk_en,
    input  logic [RA_W-13:0]  tbl_rpn,
    input  logic [7:0]        seg_limit,
    output logic              mem_req,
    output logic [RA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              cap_en,
    output exc_t              cap_val
);
    typedef struct packed {
        walk_state_e       st;
        logic [IOA_W-1:0]  addr;
        logic              is_read;
        logic [ID_W-1:0]   id;
        logic [RA_W-13:0]  pt_rpn;
        logic [6:0]        pt_pages_m1;
        logic              is64k;
        logic [RA_W-1:0]   out_addr;
        logic              fault;
        logic [1:0]        kind;
    } walk_t;

    walk_t w_d, w_q;
    logic            idx_ok;
    logic [RA_W-1:0] pte_addr;
    logic [RA_W-1:0] off_mask;
    logic [2:0]      ps_code;
    logic            perm_ok;

    ioxl_pgcalc #(.RA_W(RA_W)) i_pgcalc (
        .io_addr     (w_q.addr),
        .pt_rpn      (w_q.pt_rpn),
        .pt_pages_m1 (w_q.pt_pages_m1),
        .is64k       (w_q.is64k),
        .idx_ok      (idx_ok),
        .pte_addr    (pte_addr)
    );

    assign ps_code  = mem_rdata[2:0];
    assign off_mask = w_q.is64k ? RA_W'(16'hFFFF) : RA_W'(12'hFFF);
    assign perm_ok  = w_q.is_read ? mem_rdata[62] : mem_rdata[63];

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: if (req_valid) begin
                w_d.addr    = req_addr;
                w_d.is_read = req_is_read;
                w_d.id      = req_id;
                w_d.fault   = 1'b0;
                if (!walk_en) begin
                    w_d.out_addr = RA_W'(req_addr);
                    w_d.st       = ST_RESP;
                end else if ({1'b0, req_addr[IOA_W-1:28]} > seg_limit) begin
                    w_d.fault = 1'b1;
                    w_d.kind  = KIND_SEG;
                    w_d.st    = ST_RESP;
                end else begin
                    w_d.st = ST_SEG;
                end
            end
            ST_SEG: if (mem_rvalid) begin
                w_d.pt_rpn      = mem_rdata[RA_W-1:12];
                w_d.pt_pages_m1 = mem_rdata[11:5];
                w_d.is64k       = (ps_code == 3'd3);
                if (!mem_rdata[63] || (ps_code != 3'd1 && ps_code != 3'd3)) begin
                    w_d.fault = 1'b1;
                    w_d.kind  = KIND_SEG;
                    w_d.st    = ST_RESP;
                end else begin
                    w_d.st = ST_PG;
                end
            end
            ST_PG: begin
                if (!idx_ok) begin
                    w_d.fault = 1'b1;
                    w_d.kind  = KIND_PAGE;
                    w_d.st    = ST_RESP;
                end else if (mem_rvalid) begin
                    w_d.st = ST_RESP;
                    if (perm_ok) begin
                        w_d.out_addr = ({mem_rdata[RA_W-1:12], 12'b0} & ~off_mask) |
                                       (RA_W'(w_q.addr) & off_mask);
                    end else begin
                        w_d.fault = 1'b1;
                        w_d.kind  = KIND_PAGE;
                    end
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready = (w_q.st == ST_IDLE);
    assign rsp_valid = (w_q.st == ST_RESP);
    assign rsp_addr  = w_q.fault ? '0 : w_q.out_addr;
    assign rsp_fault = rsp_valid && w_q.fault;
    assign mem_req   = (w_q.st == ST_SEG) || (w_q.st == ST_PG && idx_ok);
    assign mem_addr  = (w_q.st == ST_SEG)
                     ? ({tbl_rpn, 12'b0} + RA_W'({w_q.addr[IOA_W-1:28], 3'b000}))
                     : pte_addr;
    assign cap_en    = rsp_fault;
    assign cap_val   = '{valid: 1'b1, kind: w_q.kind, page: w_q.addr[34:12],
                         is_read: w_q.is_read, id: w_q.id};
endmodule

// File: rtl/ioxl_top.sv
module ioxl_top
    import ioxl_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [34:0]       req_addr,
    input  logic              req_is_read,
    input  logic [10:0]       req_id,
    output logic              rsp_valid,
    output logic [RA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [RA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq
);
    logic             walk_en;
    logic [RA_W-13:0] tbl_rpn;
    logic [7:0]       seg_limit;
    logic             cap_en;
    exc_t             cap_val;
    exc_t             exc;
    logic             exc_valid;
    logic             stat_wr;

    assign exc_valid = exc.valid;
    assign stat_wr   = reg_wr && (reg_sel == SEL_STATUS);

    ioxl_regs #(.RA_W(RA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cap_en    (cap_en),
        .cap_val   (cap_val),
        .walk_en   (walk_en),
        .tbl_rpn   (tbl_rpn),
        .seg_limit (seg_limit),
        .exc       (exc),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    ioxl_walk #(.RA_W(RA_W)) i_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_is_read (req_is_read),
        .req_id      (req_id),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_addr    (rsp_addr),
        .rsp_fault   (rsp_fault),
        .walk_en     (walk_en),
        .tbl_rpn     (tbl_rpn),
        .seg_limit   (seg_limit),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .cap_en      (cap_en),
        .cap_val     (cap_val)
    );
endmodule

// File: rtl/ioxl_checker.sv
module ioxl_checker #(
    parameter int RA_W = 42
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            mem_req,
    input logic            mem_rvalid,
    input logic [RA_W-1:0] mem_addr,
    input logic            irq,
    input logic            exc_valid,
    input logic [37:0]     exc_bits,
    input logic            stat_wr
);
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_memhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_memidle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> exc_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(exc_valid) && !$past(stat_wr)) |-> (exc_bits == $past(exc_bits)));
endmodule

bind ioxl_top ioxl_checker #(.RA_W(RA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .irq        (irq),
    .exc_valid  (exc_valid),
    .exc_bits   (exc),
    .stat_wr    (stat_wr)
);

// File: tb/test_ioxl_top.sv
`timescale 1ns/1ps
module test_ioxl_top;
    localparam int RA_W = 42;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [34:0]     req_addr = '0;
    logic            req_is_read = 1'b0;
    logic [10:0]     req_id = '0;
    logic            rsp_valid;
    logic [RA_W-1:0] rsp_addr;
    logic            rsp_fault;
    logic            mem_req;
    logic [RA_W-1:0] mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [63:0]     mem_rdata = '0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_sel = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;
    int mem_txn = 0;
    int cycles = 0;
    logic [63:0] mem [logic [RA_W-1:0]];
    logic [RA_W-1:0] got_addr;
    logic            got_fault;
    int              got_txn;

    always #4 clk = ~clk;

    ioxl_top #(.RA_W(RA_W)) i_ioxl_top (.*);

    // memory model: one read at a time, data one cycle after the request
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        if (mem_req && mem_rvalid) mem_txn <= mem_txn + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_status(input logic [1:0] kind, input logic [34:0] a,
                                                input logic rd, input logic [10:0] id);
        return (64'h1 << 63) | (64'(kind) << 61) | (64'(a[34:12]) << 12) |
               (64'(rd) << 11) | 64'(id);
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [63:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic issue(input logic [34:0] a, input logic rd, input logic [10:0] id);
        int start;
        @(negedge clk);
        start = mem_txn;
        req_valid = 1'b1; req_addr = a; req_is_read = rd; req_id = id;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        got_addr  = rsp_addr;
        got_fault = rsp_valid ? rsp_fault : 1'bx;
        @(negedge clk);
        got_txn = mem_txn - start;
    endtask

    task automatic t_reset();
        check("R11 reset req_ready", 64'(req_ready), 64'd1);
        check("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R9 reset irq", 64'(irq), 64'd0);
    endtask

    task automatic t_passthrough();
        issue(35'h4_1234_5678, 1'b1, 11'h3);
        check("R1 pass addr", 64'(got_addr), 64'h4_1234_5678);
        check("R1 pass fault", 64'(got_fault), 64'd0);
        check("R1 pass no mem", 64'(got_txn), 64'd0);
    endtask

    task automatic t_setup();
        logic [63:0] v;
        write_reg(2'd0, 64'h8000_0000_0001_0003);
        write_reg(2'd1, 64'h0000_8000_0000_0000);
        read_reg(2'd0, v);
        check("R12 origin readback", v, 64'h8000_0000_0001_0003);
        read_reg(2'd1, v);
        check("R12 config readback", v, 64'h0000_8000_0000_0000);
    endtask

    task automatic t_hits();
        issue(35'h0_0000_5123, 1'b1, 11'h1);
        check("R5 4K read addr", 64'(got_addr), 64'h77_7123);
        check("R4 4K two reads", 64'(got_txn), 64'd2);
        issue(35'h0_0000_5FFF, 1'b0, 11'h1);
        check("R6 4K write ok", 64'(got_fault), 64'd0);
        issue(35'h0_1003_4567, 1'b1, 11'h2);
        check("R5 64K read addr", 64'(got_addr), 64'h1234_4567);
        issue(35'h0_0000_6ABC, 1'b0, 11'h2);
        check("R6 write-only write", 64'(got_addr), 64'h55_5ABC);
    endtask

    task automatic t_page_faults();
        logic [63:0] v;
        issue(35'h0_1003_4567, 1'b0, 11'h2A);
        check("R6 write to read-only", 64'(got_fault), 64'd1);
        read_reg(2'd2, v);
        check("R7 page status", v, exp_status(2'b10, 35'h0_1003_4567, 1'b0, 11'h2A));
        check("R9 masked irq", 64'(irq), 64'd0);
        write_reg(2'd3, 64'h2000_0000_0000_0000);
        #1 check("R9 page irq", 64'(irq), 64'd1);
        issue(35'h0_0000_6ABC, 1'b1, 11'h7);
        check("R6 read of write-only", 64'(got_fault), 64'd1);
        issue(35'h0_2000_0000, 1'b1, 11'h9);
        check("R3 invalid seg", 64'(got_fault), 64'd1);
        read_reg(2'd2, v);
        check("R8 status held", v, exp_status(2'b10, 35'h0_1003_4567, 1'b0, 11'h2A));
        write_reg(2'd2, 64'h0);
        read_reg(2'd2, v);
        check("R10 cleared", 64'(v[63]), 64'd0);
        check("R10 irq dropped", 64'(irq), 64'd0);
        issue(35'h0_0025_8000, 1'b1, 11'h4);
        check("R4 page bound fault", 64'(got_fault), 64'd1);
        check("R4 page bound one read", 64'(got_txn), 64'd1);
        read_reg(2'd2, v);
        check("R7 bound status", v, exp_status(2'b10, 35'h0_0025_8000, 1'b1, 11'h4));
        write_reg(2'd2, 64'h0);
    endtask

    task automatic t_seg_faults();
        logic [63:0] v;
        issue(35'h0_2000_0010, 1'b1, 11'h55);
        check("R3 invalid seg fault", 64'(got_fault), 64'd1);
        read_reg(2'd2, v);
        check("R7 seg status", v, exp_status(2'b11, 35'h0_2000_0010, 1'b1, 11'h55));
        check("R9 seg irq masked", 64'(irq), 64'd0);
        write_reg(2'd3, 64'h4000_0000_0000_0000);
        #1 check("R9 seg irq", 64'(irq), 64'd1);
        write_reg(2'd2, 64'h0);
        issue(35'h0_3000_0000, 1'b1, 11'h6);
        check("R3 bad size code", 64'(got_fault), 64'd1);
        write_reg(2'd2, 64'h0);
        issue(35'h0_5000_0000, 1'b0, 11'h8);
        check("R2 seg bound fault", 64'(got_fault), 64'd1);
        check("R2 seg bound no read", 64'(got_txn), 64'd0);
        read_reg(2'd2, v);
        check("R7 seg bound status", v, exp_status(2'b11, 35'h0_5000_0000, 1'b0, 11'h8));
        write_reg(2'd2, 64'h0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mem[42'h1_0000] = 64'h8000_0000_0002_0001;
        mem[42'h1_0008] = 64'h8000_0000_0003_0003;
        mem[42'h1_0018] = 64'h8000_0000_0004_0005;
        mem[42'h2_0028] = 64'hC000_0000_0077_7000;
        mem[42'h2_0030] = 64'h8000_0000_0055_5000;
        mem[42'h3_0018] = 64'h4000_0000_1234_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_setup();
        t_hits();
        t_page_faults();
        t_seg_faults();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule